// File: doc/BRIEF.md
# Byte-wide instruction prefetch queue

This block sits between an 8-bit memory bus and the instruction decoder of a CPU with variable-length instructions. An instruction can be up to six bytes long. The block keeps a small first-in first-out store of opcode bytes. It fills that store one byte per bus transfer, and only in cycles when the execution unit has left the bus free. The decoder takes bytes from the head of the store one at a time. When the store is empty, the decoder waits.

Fetching runs ahead of execution in address order from an internal fetch pointer. When a jump or call is taken, the core pulses a flush together with the target address. The flush throws away every byte held in the store and reloads the fetch pointer, so fetching starts again at the target. If a memory read was already granted when the flush arrives, that read still completes on the bus, but the byte it returns is not kept. Only one read is outstanding at any time.

Top module: `instr_prefetch_q`

## Requirements
- R1: After reset the queue is empty (`pop_valid_o` low), and `mem_addr_o` equals the parameter `RESET_ADDR`.
- R2: `mem_req_o` is never high in a cycle where `bus_busy_i` is high.
- R3: At most one read is outstanding. After a request is granted, `mem_req_o` stays low until the cycle after that read's `mem_rvalid_i`.
- R4: Each granted read is followed by a fetch address exactly one higher. Bytes therefore reach the decoder in ascending address order.
- R5: The queue holds at most `DEPTH` bytes (default 4). While it is full, `mem_req_o` stays low.
- R6: A pop while the queue is empty has no effect. The next byte delivered is still the next byte in address order.
- R7: When a byte arrives and is popped in the same cycle, the number of queued bytes does not change.
- R8: The cycle after `flush_i` is high, the queue is empty and `mem_addr_o` equals the `flush_addr_i` sampled with the flush. The bytes delivered after that start at that address.
- R9: If a read is in flight when `flush_i` is high, its returned byte is discarded. This holds whether the byte returns in the flush cycle or later.
- R10: `mem_req_o` is low in any cycle where `flush_i` is high.
- R11: `pop_data_o` always shows the oldest queued byte, and a pop moves on to the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_busy_i | input | 1 | Execution unit owns the bus this cycle |
| flush_i | input | 1 | Jump/call taken: discard queue and restart fetching |
| flush_addr_i | input | AW | Restart address, valid with `flush_i` |
| mem_req_o | output | 1 | Read request for one byte |
| mem_addr_o | output | AW | Byte address of the request |
| mem_gnt_i | input | 1 | Memory accepts the request this cycle |
| mem_rvalid_i | input | 1 | Read data returned this cycle |
| mem_rdata_i | input | 8 | Returned byte |
| pop_i | input | 1 | Decoder takes the head byte |
| pop_valid_o | output | 1 | Queue holds at least one byte |
| pop_data_o | output | 8 | Head byte of the queue |

## Verification
The properties assume the following about the inputs:
- The memory treats `mem_gnt_i` as meaningful only while `mem_req_o` is high.
- The memory answers every granted read with exactly one `mem_rvalid_i` pulse, at least one cycle after the grant.
- `flush_addr_i` is valid whenever `flush_i` is high.

The bench's memory model keeps to these rules. It accepts a request only when request and grant are both high, and it returns each byte after a latency the bench sets to one or three cycles. The data value is a fixed function of the address, so ordering errors are visible. The bench changes busy, grant, pop and flush only just after a clock edge, so each scenario lands on a known cycle. That timing is used to place a flush in the same cycle as a returning byte, to place a flush ahead of a slow return, and to make a push and a pop coincide.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] pfq_byte_t;

    // State of the single fetch slot
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,   // no read outstanding
        FS_WAIT = 2'd1,   // read granted, byte will be queued
        FS_DROP = 2'd2    // read granted before a flush, byte will be discarded
    } fetch_st_e;

endpackage

// File: rtl/pfq_fetch.sv
module pfq_fetch #(
    parameter int              AW         = 16,
    parameter logic [AW-1:0]   RESET_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic [AW-1:0] flush_addr_i,
    input  logic          bus_busy_i,
    input  logic          room_i,
    input  logic          gnt_i,
    input  logic          rvalid_i,
    output logic          req_o,
    output logic [AW-1:0] addr_o,
    output logic          push_o
);
    import pfq_pkg::*;

    typedef struct packed {
        logic [AW-1:0] addr;
        fetch_st_e     st;
    } fetch_t;

    fetch_t state_d, state_q;
    logic   req_c;
    logic   push_c;

    always_comb begin
        state_d = state_q;
        push_c  = 1'b0;
        req_c   = !flush_i && !bus_busy_i && room_i && (state_q.st == FS_IDLE);

        case (state_q.st)
            FS_IDLE: begin
                if (req_c && gnt_i) begin
                    state_d.addr = state_q.addr + AW'(1);
                    state_d.st   = FS_WAIT;
                end
            end
            FS_WAIT: begin
                if (rvalid_i) begin
                    push_c     = !flush_i;
                    state_d.st = FS_IDLE;
                end else if (flush_i) begin
                    state_d.st = FS_DROP;
                end
            end
            FS_DROP: begin
                if (rvalid_i) begin
                    state_d.st = FS_IDLE;
                end
            end
            default: state_d.st = FS_IDLE;
        endcase

        if (flush_i) begin
            state_d.addr = flush_addr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.addr <= RESET_ADDR;
            state_q.st   <= FS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign req_o  = req_c;
    assign addr_o = state_q.addr;
    assign push_o = push_c;

endmodule

// File: rtl/pfq_fifo.sv
module pfq_fifo #(
    parameter int DEPTH = 4,
    parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               push_i,
    input  pfq_pkg::pfq_byte_t push_data_i,
    input  logic               pop_i,
    output logic               valid_o,
    output pfq_pkg::pfq_byte_t data_o,
    output logic [CW-1:0]      count_o
);
    import pfq_pkg::*;

    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][BYTE_W-1:0] mem;
        logic [PW-1:0]                rd;
        logic [PW-1:0]                wr;
        logic [CW-1:0]                cnt;
    } fifo_t;

    fifo_t fifo_d, fifo_q;
    logic  do_pop, do_push;

    always_comb begin
        fifo_d  = fifo_q;
        do_pop  = pop_i && (fifo_q.cnt != '0);
        do_push = push_i && ((fifo_q.cnt != FULL) || do_pop);

        if (clr_i) begin
            fifo_d.rd  = '0;
            fifo_d.wr  = '0;
            fifo_d.cnt = '0;
        end else begin
            if (do_push) begin
                fifo_d.mem[fifo_q.wr] = push_data_i;
                fifo_d.wr = (fifo_q.wr == LAST) ? '0 : fifo_q.wr + PW'(1);
            end
            if (do_pop) begin
                fifo_d.rd = (fifo_q.rd == LAST) ? '0 : fifo_q.rd + PW'(1);
            end
            fifo_d.cnt = fifo_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_q.mem <= '0;
            fifo_q.rd  <= '0;
            fifo_q.wr  <= '0;
            fifo_q.cnt <= '0;
        end else begin
            fifo_q <= fifo_d;
        end
    end

    assign valid_o = (fifo_q.cnt != '0);
    assign data_o  = fifo_q.mem[fifo_q.rd];
    assign count_o = fifo_q.cnt;

endmodule

// File: rtl/instr_prefetch_q.sv
module instr_prefetch_q #(
    parameter int            AW         = 16,
    parameter int            DEPTH      = 4,
    parameter logic [AW-1:0] RESET_ADDR = 16'h0100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_busy_i,
    input  logic          flush_i,
    input  logic [AW-1:0] flush_addr_i,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic          mem_gnt_i,
    input  logic          mem_rvalid_i,
    input  logic [7:0]    mem_rdata_i,
    input  logic          pop_i,
    output logic          pop_valid_o,
    output logic [7:0]    pop_data_o
);
    localparam int            CW   = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic          room;
    logic          push;
    logic [CW-1:0] occ;

    assign room = (occ != FULL);

    pfq_fetch #(
        .AW         (AW),
        .RESET_ADDR (RESET_ADDR)
    ) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush_i),
        .flush_addr_i (flush_addr_i),
        .bus_busy_i   (bus_busy_i),
        .room_i       (room),
        .gnt_i        (mem_gnt_i),
        .rvalid_i     (mem_rvalid_i),
        .req_o        (mem_req_o),
        .addr_o       (mem_addr_o),
        .push_o       (push)
    );

    pfq_fifo #(
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (flush_i),
        .push_i      (push),
        .push_data_i (mem_rdata_i),
        .pop_i       (pop_i && !flush_i),
        .valid_o     (pop_valid_o),
        .data_o      (pop_data_o),
        .count_o     (occ)
    );

endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
    parameter int AW    = 16,
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_busy_i,
    input logic          flush_i,
    input logic [AW-1:0] flush_addr_i,
    input logic          mem_req_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_gnt_i,
    input logic          mem_rvalid_i,
    input logic          pop_valid_o,
    input logic [CW-1:0] occ
);
    AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !bus_busy_i); // R2

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_gnt_i) |=> !mem_req_o); // R3

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_gnt_i) |=> (mem_addr_o == AW'($past(mem_addr_o) + 1'b1))); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH)); // R5

    AST_FULL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CW'(DEPTH)) |-> !mem_req_o); // R5

    AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_valid_o && !mem_rvalid_i) |=> !pop_valid_o); // R6

    AST_FLUSH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (!pop_valid_o && mem_addr_o == $past(flush_addr_i))); // R8

    AST_NO_REQ_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> !mem_req_o); // R10

endmodule

bind instr_prefetch_q pfq_checker #(
    .AW    (AW),
    .DEPTH (DEPTH),
    .CW    (CW)
) u_pfq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_busy_i   (bus_busy_i),
    .flush_i      (flush_i),
    .flush_addr_i (flush_addr_i),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_gnt_i    (mem_gnt_i),
    .mem_rvalid_i (mem_rvalid_i),
    .pop_valid_o  (pop_valid_o),
    .occ          (occ)
);

// File: tb/tb_instr_prefetch_q.sv
module tb_instr_prefetch_q;
    localparam int          AW  = 16;
    localparam logic [15:0] RST = 16'h0100;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_busy, flush, gnt, pop;
    logic [15:0] flush_addr;
    logic        req, pop_valid;
    logic [15:0] addr;
    logic        rvalid;
    logic [7:0]  rdata, pop_data;

    int total = 0;
    int bad   = 0;
    int lat   = 1;
    int cnt   = 0;
    int accepts = 0;
    int popped  = 0;
    bit done    = 0;
    logic [15:0] raddr;
    logic [7:0]  exp_q[$];

    always #2 clk = ~clk;

    instr_prefetch_q dut (
        .clk(clk), .rst_n(rst_n), .bus_busy_i(bus_busy), .flush_i(flush),
        .flush_addr_i(flush_addr), .mem_req_o(req), .mem_addr_o(addr),
        .mem_gnt_i(gnt), .mem_rvalid_i(rvalid), .mem_rdata_i(rdata),
        .pop_i(pop), .pop_valid_o(pop_valid), .pop_data_o(pop_data)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    // memory model: one response per accepted read, after lat cycles
    always @(posedge clk) begin
        rvalid <= 1'b0;
        if (cnt != 0) begin
            cnt <= cnt - 1;
            if (cnt == 1) begin
                rvalid <= 1'b1;
                rdata  <= mem_byte(raddr);
            end
        end
        if (rst_n && req && gnt) begin
            accepts <= accepts + 1;
            raddr   <= addr;
            if (lat == 1) begin
                rvalid <= 1'b1;
                rdata  <= mem_byte(addr);
            end else begin
                cnt <= lat - 1;
            end
        end
    end

    // monitor: scoreboard compare on consumed bytes, protocol watch
    always @(negedge clk) begin
        if (rst_n) begin
            if (pop && pop_valid && !flush) begin
                total++;
                if (exp_q.size() == 0) begin
                    bad++;
                    $display("FAIL R11: byte %02h popped, expected none", pop_data);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    if (pop_data !== e) begin
                        bad++;
                        $display("FAIL R4/R11: popped %02h expected %02h", pop_data, e);
                    end
                end
                popped++;
            end
            if (req && (cnt != 0 || rvalid)) begin
                bad++;
                $display("FAIL R3: request %0d expected 0 while read outstanding", req);
            end
            if (req && bus_busy) begin
                bad++;
                $display("FAIL R2: request %0d expected 0 while bus busy", req);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic expect_run(input logic [15:0] start, input int n);
        exp_q.delete();
        for (int i = 0; i < n; i++) exp_q.push_back(mem_byte(start + 16'(i)));
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            total += 2; // continuous R2 / R3 watches
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        finish_up();
    end

    initial begin
        int p0, a0;
        rst_n = 1'b0; bus_busy = 1'b1; gnt = 1'b0; flush = 1'b0; pop = 1'b0;
        flush_addr = '0;
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pop_valid == 1'b0, "R1 empty", pop_valid, 0);
        chk(addr == RST, "R1 addr", addr, RST);
        chk(req == 1'b0, "R2 busy at start", req, 0);
        expect_run(RST, 64);

        // R5: fill to depth and stop
        step(); bus_busy = 0; gnt = 1;
        cyc(20);
        @(negedge clk);
        chk(accepts == 4, "R5 fetch count", accepts, 4);
        chk(req == 1'b0, "R5 no req when full", req, 0);
        chk(pop_valid == 1'b1, "R5 valid when full", pop_valid, 1);

        // R11/R4: drain in order with bus busy
        step(); bus_busy = 1; pop = 1;
        cyc(4); pop = 0;
        @(negedge clk);
        chk(popped == 4, "R11 drained", popped, 4);
        chk(pop_valid == 1'b0, "R11 empty after drain", pop_valid, 0);

        // R6 / R2: pops on empty queue, busy bus, grant offered
        a0 = accepts;
        step(); pop = 1;
        cyc(5); pop = 0;
        @(negedge clk);
        chk(popped == 4, "R6 no pop on empty", popped, 4);
        chk(pop_valid == 1'b0, "R6 still empty", pop_valid, 0);
        chk(accepts == a0, "R2 no fetch while busy", accepts, a0);
        step(); bus_busy = 0;
        cyc(10);
        step(); bus_busy = 1; pop = 1; // R6 next byte is 0x104 (scoreboard)
        step(); pop = 0;

        // R7: push and pop in the same cycle keep the count at 3
        bus_busy = 0; gnt = 0;
        step(); gnt = 1;
        step(); gnt = 0; bus_busy = 1; pop = 1;
        step(); pop = 0;
        p0 = popped;
        pop = 1;
        cyc(6); pop = 0;
        @(negedge clk);
        chk(popped - p0 == 3, "R7 count kept", popped - p0, 3);

        // R8/R10: flush with bytes queued and request pending
        step(); bus_busy = 0; gnt = 1;
        cyc(12);
        bus_busy = 1; pop = 1;
        cyc(2); pop = 0;
        bus_busy = 0; gnt = 0; flush = 1; flush_addr = 16'h2000;
        @(negedge clk);
        chk(req == 1'b0, "R10 no req in flush", req, 0);
        expect_run(16'h2000, 64);
        step(); flush = 0;
        @(negedge clk);
        chk(pop_valid == 1'b0, "R8 queue cleared", pop_valid, 0);
        chk(addr == 16'h2000, "R8 restart addr", addr, 16'h2000);
        step(); gnt = 1;
        cyc(12);
        bus_busy = 1; p0 = popped; pop = 1;
        cyc(4); pop = 0;
        chk(popped - p0 == 4, "R8 bytes from target", popped - p0, 4);

        // R9: flush in the cycle the byte returns (latency 1)
        bus_busy = 0; gnt = 1;
        step(); gnt = 0; flush = 1; flush_addr = 16'h3000;
        expect_run(16'h3000, 64);
        step(); flush = 0; bus_busy = 1;
        @(negedge clk);
        chk(pop_valid == 1'b0, "R9 same-cycle byte dropped", pop_valid, 0);
        step(); bus_busy = 0; gnt = 1;
        cyc(12);
        bus_busy = 1; p0 = popped; pop = 1;
        cyc(4); pop = 0;
        chk(popped - p0 == 4, "R9 refill after drop", popped - p0, 4);

        // R9: flush ahead of a slow return (latency 3)
        lat = 3;
        bus_busy = 0; gnt = 1;
        step(); flush = 1; flush_addr = 16'h4000;
        expect_run(16'h4000, 64);
        step(); flush = 0; bus_busy = 1;
        cyc(5);
        @(negedge clk);
        chk(pop_valid == 1'b0, "R9 late byte dropped", pop_valid, 0);
        step(); bus_busy = 0;
        cyc(30);
        bus_busy = 1; p0 = popped; pop = 1;
        cyc(4); pop = 0;
        chk(popped - p0 == 4, "R9 restart after slow drop", popped - p0, 4);

        // R4/R7: streaming with pops and fills overlapping
        lat = 1;
        step(); bus_busy = 0; gnt = 1; p0 = popped; pop = 1;
        cyc(40); pop = 0;
        @(negedge clk);
        chk(popped - p0 >= 15, "R4 streaming throughput", popped - p0, 15);

        cyc(2);
        finish_up();
    end

endmodule